// File: doc/BRIEF.md
# Multichannel single-phase audio frame serializer

This block turns a set of parallel audio sample words into one serial TDM stream. Every frame opens with a frame-sync strobe that lasts one bit-clock period. The enabled channel words follow straight after it on the serial data line, with no gaps between them. All timing comes from the incoming bit clock, and every output changes on its rising edge. A receiver samples the line on the falling edge.

The number of slots comes from the channel mask: it runs from slot 0 up to the highest mask bit that is set. Data starts one bit after the sync strobe. When the frame is filled exactly, the final LSB therefore spills into the sync cycle of the next frame. When the frame is longer than the data, the remaining cycles carry zeros. Samples are fetched once per frame through a valid/acknowledge pair. The frame length, word length and mask are also captured once per frame, so a change part-way through a frame does not disturb it.

Top module: `tdm_dsp_tx`

## Requirements
- R1: `wclk` is high for exactly one bit-clock cycle at the start of each frame. While enabled, frames repeat every `frame_len` cycles, using the `frame_len` captured at that frame's start.
- R2: Each word is `word_len` bits long, taken from bits [word_len-1:0] of its 24-bit channel field (channel c occupies `smp_data[c*24 +: 24]`). Words are sent MSB first. Channel 0's MSB appears in the cycle after the sync cycle, and later channels follow back-to-back.
- R3: The slot count is the index of the highest set bit of `ch_mask` plus one. A slot below that position whose mask bit is clear is sent as `word_len` zeros and receives no acknowledge.
- R4: Every cycle after the last data bit up to the end of the frame carries `sdata` = 0.
- R5: When `frame_len` equals `word_len` times the slot count, the last LSB of a frame appears in the next sync cycle, while `wclk` is high.
- R6: `cfg_err` is high while `word_len` is outside 8..24, while `ch_mask` is zero, or while `frame_len` is less than `word_len` times the slot count. No frame starts while it is high.
- R7: `smp_ack[c]` is high, for each channel c whose mask bit is set, in the cycle just before a sync cycle. The sample present in that cycle is the one transmitted in the frame that follows.
- R8: An acknowledged channel whose `smp_valid` bit is low is sent as all zeros. It also sets `underrun`, which stays high until reset.
- R9: Configuration changes made during a frame do not affect that frame. They take effect at the next frame start.
- R10: With the block idle, raising `en` under a valid configuration gives a sync cycle right after the next edge. When `en` is low at a frame's end, framing stops, and both outputs stay low after any spilled LSB.
- R11: After reset, `wclk`, `sdata` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Framing enable |
| frame_len | input | 10 | Bit clocks per frame |
| word_len | input | 5 | Bits per sample word (8..24) |
| ch_mask | input | 8 | Channel enable mask |
| smp_data | input | 192 | Per-channel sample words, 24 bits each, right-justified |
| smp_valid | input | 8 | Per-channel sample present |
| smp_ack | output | 8 | Per-channel sample taken at this edge |
| wclk | output | 1 | Frame-sync strobe |
| sdata | output | 1 | Serial data |
| cfg_err | output | 1 | Live configuration is unusable |
| underrun | output | 1 | Sticky missing-sample flag |

## Verification
The assertions rely on the configuration captured at each frame start being legal. In particular, a frame of at least eight cycles and a word that fits the frame are what keep the sync strobe one cycle wide and leave at most one bit pending at each boundary. The stimulus meets this: every configuration the bench writes is either legal or reported by `cfg_err`. The block refuses to start a frame under an unusable setting, so no illegal setting is ever captured. All inputs change a quarter period after the rising edge, so the block and the bench's queue-based model see the same values at each edge.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  // Number of transmitted slots: one past the highest set mask bit.
  function automatic int top_slots(input logic [31:0] mask);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++)
      if (mask[i]) n = i + 1;
    return n;
  endfunction

  // Bit clocks occupied by the data of one frame.
  function automatic int bits_needed(input int wl, input int nslots);
    return wl * nslots;
  endfunction

endpackage

// File: rtl/tdm_cfg_chk.sv
module tdm_cfg_chk
  import tdm_tx_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int MAX_WL = 24,
  parameter int MIN_WL = 8,
  parameter int FLW    = 10,
  parameter int WLW    = 5,
  parameter int NCHW   = 4
) (
  input  logic [FLW-1:0]    frame_len,
  input  logic [WLW-1:0]    word_len,
  input  logic [MAX_CH-1:0] ch_mask,
  output logic [NCHW-1:0]   nch,
  output logic              cfg_bad
);

  int slots_i;
  int need_i;

  always_comb begin
    slots_i = top_slots(32'(ch_mask));
    need_i  = bits_needed(int'(word_len), slots_i);
    nch     = NCHW'(slots_i);
    cfg_bad = (int'(word_len) < MIN_WL) || (int'(word_len) > MAX_WL) ||
              (slots_i == 0) || (int'(frame_len) < need_i);
  end

endmodule

// File: rtl/tdm_frame_ctl.sv
module tdm_frame_ctl #(
  parameter int FLW = 10
) (
  input  logic           bclk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [FLW-1:0] frame_len,
  output logic           run,
  output logic           frm_start,
  output logic           wclk_q
);

  logic [FLW-1:0] pos;
  logic [FLW-1:0] flen_q;
  logic           at_last;
  logic           frm_stop;

  assign at_last   = run && (pos == flen_q - 1'b1);
  assign frm_start = go && (!run || at_last);
  assign frm_stop  = at_last && !go;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      pos    <= '0;
      flen_q <= '0;
      wclk_q <= 1'b0;
    end else begin
      wclk_q <= frm_start;
      if (frm_start) begin
        run    <= 1'b1;
        pos    <= '0;
        flen_q <= frame_len;
      end else if (frm_stop) begin
        run <= 1'b0;
        pos <= '0;
      end else if (run) begin
        pos <= pos + 1'b1;
      end
    end
  end

  AST_SYNC_ONE_CYCLE: assert property (@(posedge bclk) disable iff (!rst_n)
    wclk_q |=> !wclk_q); // R1
  AST_POS_BOUND: assert property (@(posedge bclk) disable iff (!rst_n)
    run |-> (pos < flen_q)); // R1

endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq #(
  parameter int MAX_CH = 8,
  parameter int MAX_WL = 24,
  parameter int WLW    = 5,
  parameter int NCHW   = 4,
  parameter int CHW    = 3
) (
  input  logic                     bclk,
  input  logic                     rst_n,
  input  logic                     frm_start,
  input  logic [WLW-1:0]           word_len,
  input  logic [MAX_CH-1:0]        ch_mask,
  input  logic [NCHW-1:0]          nch,
  input  logic [MAX_CH*MAX_WL-1:0] smp_data,
  input  logic [MAX_CH-1:0]        smp_valid,
  output logic [MAX_CH-1:0]        smp_ack,
  output logic                     sdata_q,
  output logic                     underrun_q
);

  logic [MAX_WL-1:0] shadow [MAX_CH];
  logic [MAX_CH-1:0] starve;
  logic [CHW-1:0]    ch_c;
  logic [WLW-1:0]    bit_c;
  logic [WLW-1:0]    wl_q;
  logic [NCHW-1:0]   nch_q;
  logic              dact;
  logic              last_slot;
  logic              cur_bit;

  // One capture register per channel, loaded at the frame boundary.
  for (genvar g = 0; g < MAX_CH; g++) begin : g_chan
    assign smp_ack[g] = frm_start & ch_mask[g];
    assign starve[g]  = smp_ack[g] & ~smp_valid[g];

    always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n)
        shadow[g] <= '0;
      else if (frm_start)
        shadow[g] <= (ch_mask[g] && smp_valid[g]) ? smp_data[g*MAX_WL +: MAX_WL] : '0;
    end
  end

  assign last_slot = (NCHW'(ch_c) + NCHW'(1)) == nch_q;
  // A bit still pending at a boundary is the previous frame's LSB.
  assign cur_bit   = dact ? shadow[ch_c][bit_c] : 1'b0;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_q    <= 1'b0;
      underrun_q <= 1'b0;
      ch_c       <= '0;
      bit_c      <= '0;
      wl_q       <= '0;
      nch_q      <= '0;
      dact       <= 1'b0;
    end else begin
      sdata_q    <= cur_bit;
      underrun_q <= underrun_q | (|starve);
      if (frm_start) begin
        ch_c  <= '0;
        bit_c <= word_len - 1'b1;
        wl_q  <= word_len;
        nch_q <= nch;
        dact  <= 1'b1;
      end else if (dact) begin
        if (bit_c == '0) begin
          if (last_slot) begin
            dact <= 1'b0;
          end else begin
            ch_c  <= ch_c + 1'b1;
            bit_c <= wl_q - 1'b1;
          end
        end else begin
          bit_c <= bit_c - 1'b1;
        end
      end
    end
  end

  AST_TAIL_FITS: assert property (@(posedge bclk) disable iff (!rst_n)
    frm_start |-> (!dact || (last_slot && bit_c == '0))); // R5
  AST_WORD_BITS: assert property (@(posedge bclk) disable iff (!rst_n)
    dact |-> (bit_c < wl_q)); // R2
  AST_UNDERRUN_STICKY: assert property (@(posedge bclk) disable iff (!rst_n)
    underrun_q |=> underrun_q); // R8

endmodule

// File: rtl/tdm_dsp_tx.sv
module tdm_dsp_tx #(
  parameter int MAX_CH = 8,
  parameter int MAX_WL = 24,
  parameter int MIN_WL = 8,
  parameter int FLW    = 10,
  localparam int WLW   = $clog2(MAX_WL + 1),
  localparam int NCHW  = $clog2(MAX_CH + 1),
  localparam int CHW   = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic                     bclk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [FLW-1:0]           frame_len,
  input  logic [WLW-1:0]           word_len,
  input  logic [MAX_CH-1:0]        ch_mask,
  input  logic [MAX_CH*MAX_WL-1:0] smp_data,
  input  logic [MAX_CH-1:0]        smp_valid,
  output logic [MAX_CH-1:0]        smp_ack,
  output logic                     wclk,
  output logic                     sdata,
  output logic                     cfg_err,
  output logic                     underrun
);

  logic [NCHW-1:0] nch;
  logic            cfg_bad;
  logic            run;
  logic            frm_start;

  tdm_cfg_chk #(
    .MAX_CH(MAX_CH), .MAX_WL(MAX_WL), .MIN_WL(MIN_WL),
    .FLW(FLW), .WLW(WLW), .NCHW(NCHW)
  ) u_cfg (
    .frame_len(frame_len),
    .word_len (word_len),
    .ch_mask  (ch_mask),
    .nch      (nch),
    .cfg_bad  (cfg_bad)
  );

  tdm_frame_ctl #(.FLW(FLW)) u_frm (
    .bclk     (bclk),
    .rst_n    (rst_n),
    .go       (en & ~cfg_bad),
    .frame_len(frame_len),
    .run      (run),
    .frm_start(frm_start),
    .wclk_q   (wclk)
  );

  tdm_slot_seq #(
    .MAX_CH(MAX_CH), .MAX_WL(MAX_WL), .WLW(WLW), .NCHW(NCHW), .CHW(CHW)
  ) u_seq (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .frm_start (frm_start),
    .word_len  (word_len),
    .ch_mask   (ch_mask),
    .nch       (nch),
    .smp_data  (smp_data),
    .smp_valid (smp_valid),
    .smp_ack   (smp_ack),
    .sdata_q   (sdata),
    .underrun_q(underrun)
  );

  assign cfg_err = cfg_bad;

  AST_ACK_THEN_SYNC: assert property (@(posedge bclk) disable iff (!rst_n)
    (|smp_ack) |=> wclk); // R7
  AST_NO_FRAME_ON_ERR: assert property (@(posedge bclk) disable iff (!rst_n)
    cfg_err |=> !wclk); // R6
  AST_IDLE_NO_SYNC: assert property (@(posedge bclk) disable iff (!rst_n)
    (!run && !en) |=> !wclk); // R10

endmodule

// File: tb/tb_tdm_dsp_tx.sv
module tb_tdm_dsp_tx;
  localparam int NC = 8;
  localparam int WM = 24;
  localparam int FW = 10;

  logic              bclk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [FW-1:0]     frame_len = 10'd64;
  logic [4:0]        word_len = 5'd16;
  logic [NC-1:0]     ch_mask = 8'h03;
  logic [NC-1:0]     smp_valid = 8'hFF;
  logic [NC*WM-1:0]  smp_data = '0;
  logic [NC-1:0]     smp_ack;
  logic              wclk, sdata, cfg_err, underrun;

  always #10 bclk = ~bclk;   // 50 MHz

  tdm_dsp_tx dut (
    .bclk(bclk), .rst_n(rst_n), .en(en), .frame_len(frame_len),
    .word_len(word_len), .ch_mask(ch_mask), .smp_data(smp_data),
    .smp_valid(smp_valid), .smp_ack(smp_ack), .wclk(wclk), .sdata(sdata),
    .cfg_err(cfg_err), .underrun(underrun)
  );

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  string tag = "R11";
  bit    checking = 1'b0;

  // Behavioural reference: a bit queue filled at each frame start.
  bit    m_run = 1'b0;
  int    m_pos = 0;
  int    m_F = 0;
  bit    q[$];
  bit    exp_w = 1'b0;
  bit    exp_s = 1'b0;
  bit    m_under = 1'b0;
  int unsigned seed = 32'h1234_5678;

  function automatic int slots(input logic [NC-1:0] m);
    int n = 0;
    for (int i = 0; i < NC; i++) if (m[i]) n = i + 1;
    return n;
  endfunction

  function automatic bit m_bad();
    int n = slots(ch_mask);
    return (word_len < 8) || (word_len > 24) || (n == 0) ||
           (int'(frame_len) < int'(word_len) * n);
  endfunction

  function automatic bit m_start();
    return en && !m_bad() && (!m_run || m_pos == m_F - 1);
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge bclk) begin : model
    bit st;
    bit last;
    int n;
    if (!rst_n) begin
      m_run = 1'b0; m_pos = 0; m_F = 0; q.delete();
      exp_w = 1'b0; exp_s = 1'b0; m_under = 1'b0;
    end else begin
      st   = m_start();
      last = m_run && (m_pos == m_F - 1);
      n    = slots(ch_mask);
      exp_s = (q.size() > 0) ? q.pop_front() : 1'b0;
      exp_w = st;
      if (st) begin
        m_run = 1'b1; m_pos = 0; m_F = int'(frame_len);
        for (int c = 0; c < n; c++) begin
          if (ch_mask[c] && !smp_valid[c]) m_under = 1'b1;
          for (int b = int'(word_len) - 1; b >= 0; b--)
            q.push_back((ch_mask[c] && smp_valid[c]) ? smp_data[c*WM + b] : 1'b0);
        end
      end else if (last) begin
        m_run = 1'b0; m_pos = 0;
      end else if (m_run) begin
        m_pos++;
      end
    end
  end

  // New samples after each frame start, away from the edge.
  always @(posedge bclk) begin
    #5;
    if (rst_n && exp_w)
      for (int c = 0; c < NC; c++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        smp_data[c*WM +: WM] = seed[31:8];
      end
  end

  // Every-cycle comparison on the falling edge.
  always @(negedge bclk) begin
    if (checking && rst_n) begin
      check("wclk", 32'(wclk), 32'(exp_w));
      check("sdata", 32'(sdata), 32'(exp_s));
      check("cfg_err", 32'(cfg_err), 32'(m_bad()));
      check("underrun", 32'(underrun), 32'(m_under));
      check("smp_ack", 32'(smp_ack), m_start() ? 32'(ch_mask) : 32'd0);
    end
  end

  always @(posedge bclk) begin
    cyc++;
    if (cyc > 50000) begin
      total++; bad++;
      $display("FAIL %s watchdog actual=%0d expected=done", tag, cyc);
      finish_run();
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge bclk);
    #5;
  endtask

  task automatic set_cfg(input int fl, input int wl, input logic [NC-1:0] m);
    frame_len = FW'(fl); word_len = 5'(wl); ch_mask = m;
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    @(negedge bclk);
    tag = "R11";
    check("reset wclk", 32'(wclk), 0);
    check("reset sdata", 32'(sdata), 0);
    check("reset underrun", 32'(underrun), 0);
    checking = 1'b1;

    tag = "R10"; // start one edge after enable
    cycles(1);
    en = 1'b1;
    @(posedge bclk); @(negedge bclk);
    check("start latency wclk", 32'(wclk), 1);

    tag = "R1";  cycles(200);
    tag = "R2";  set_cfg(64, 20, 8'h03); cycles(200);
    tag = "R4";  set_cfg(64, 12, 8'h03); cycles(150);
    tag = "R3";  set_cfg(32, 8, 8'h05);  cycles(120);
    set_cfg(64, 8, 8'h80); cycles(150);
    tag = "R5";  set_cfg(32, 8, 8'h0F);  cycles(120);
    set_cfg(24, 24, 8'h01); cycles(100);
    set_cfg(192, 24, 8'hFF); cycles(420);
    tag = "R7";  set_cfg(40, 10, 8'h0A); cycles(120);

    tag = "R8";
    set_cfg(64, 16, 8'h03);
    smp_valid = 8'hFD; cycles(80);
    smp_valid = 8'hFF; cycles(80);
    check("underrun held", 32'(underrun), 1);

    tag = "R9";
    while (!wclk) cycles(1);
    cycles(10);
    set_cfg(48, 20, 8'h01); cycles(20);
    ch_mask = 8'h07; word_len = 5'd12; cycles(150);

    tag = "R6";
    set_cfg(20, 16, 8'h03); cycles(100);
    check("cfg_err short frame", 32'(cfg_err), 1);
    set_cfg(64, 7, 8'h03); cycles(60);
    set_cfg(64, 25, 8'h03); cycles(60);
    set_cfg(64, 16, 8'h00); cycles(60);
    check("cfg_err empty mask", 32'(cfg_err), 1);
    set_cfg(64, 16, 8'h03); cycles(100);

    tag = "R10";
    set_cfg(32, 8, 8'h0F); cycles(50);
    en = 1'b0; cycles(80);
    check("stopped wclk", 32'(wclk), 0);
    check("stopped sdata", 32'(sdata), 0);
    en = 1'b1;
    @(posedge bclk); @(negedge bclk);
    check("restart latency wclk", 32'(wclk), 1);
    cycles(100);

    finish_run();
  end

endmodule